// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock of an I2C master from a fast functional clock. A programmable divider turns the functional clock into a slower internal tick. Two programmable counts then set how many ticks SCL spends low and high. The length of each phase is not the raw count: a fixed offset of seven ticks is added, minus a trim equal to the divider setting limited to two. Software therefore programs a count a few ticks below the wanted phase length.

The bit engine beside it asks for a run, and later for a stop. While running, the block pulls SCL low for the low phase and releases it for the high phase. It gives two single-cycle strobes. The change strobe marks the first cycle of every low phase, where SDA may move. The sample strobe marks the middle of every high phase, where SDA is read. A stop request lets the current period finish: the block returns to idle once a high phase ends. The divider and the two counts are captured at each phase boundary, so changes made during a phase never bend that phase. With a divider of zero on a 12 MHz module clock, counts of 53 give 100 kHz and counts of 8 give 400 kHz.

Top module: `i2c_scl_timer`

## Requirements
- R1: Out of reset and whenever `active` is 0, `scl_pull` is 0 (SCL released) and neither strobe is asserted.
- R2: A tick occurs once every `psc_div`+1 functional clock cycles, so a phase of L ticks lasts exactly L*(`psc_div`+1) cycles of `scl_pull` holding its level.
- R3: A low phase lasts `low_cnt` + 7 - min(`psc_div`, 2) ticks.
- R4: A high phase lasts `high_cnt` + 7 - min(`psc_div`, 2) ticks.
- R5: With `psc_div` = 0, counts of 53 give a period of 120 cycles (100 kHz from 12 MHz), and counts of 8 give a period of 30 cycles (400 kHz).
- R6: `run_req` seen while idle starts a low phase in the next cycle (`active` = 1, `scl_pull` = 1). `run_req` seen while active has no effect on the phase lengths.
- R7: `chg_stb` is high for exactly one cycle, the first cycle of each low phase. `smp_stb` is high for exactly one cycle in each high phase of L ticks, the first cycle of tick floor(L/2) counted from 0. That is cycle floor(L/2)*(P+1)+1 of the phase, counted from 1.
- R8: `psc_div`, `low_cnt` and `high_cnt` are captured only at a phase start. A change made during a phase takes effect from the next phase.
- R9: `stop_req` seen while active, in any cycle up to and including the last cycle of a high phase, returns the block to idle at the end of that high phase. `stop_req` seen while idle is ignored and does not shorten a later run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_req | input | 1 | Start request from the bit engine |
| stop_req | input | 1 | Stop request from the bit engine |
| psc_div | input | PSC_W | Divider setting; tick every psc_div+1 cycles |
| low_cnt | input | TIME_W | Low-phase count before offset |
| high_cnt | input | TIME_W | High-phase count before offset |
| scl_pull | output | 1 | 1 = drive SCL low, 0 = release |
| chg_stb | output | 1 | SDA change point strobe |
| smp_stb | output | 1 | SDA sample point strobe |
| active | output | 1 | Generator is running |

## Verification
A stop request and the end of a high phase can fall in the same cycle. The bench places `stop_req` exactly on the last cycle of the first high phase and expects one period and then idle. It repeats this with the request one cycle later and expects a second full period. A second collision is a register write during a running phase. The bench changes the divider and both counts in mid-phase and, while running, adds a `run_req`. A scoreboard then compares every phase length and strobe position against the values worked out from the capture-at-boundary rule.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Phase length in ticks: count plus offset, less the divider clipped at cap.
  function automatic int unsigned phase_ticks(int unsigned count_v,
                                              int unsigned div_v,
                                              int unsigned offs,
                                              int unsigned cap);
    int unsigned trim;
    trim = (div_v > cap) ? cap : div_v;
    return count_v + offs - trim;
  endfunction

  // Tick index (from 0) that carries the sample point of a high phase.
  function automatic int unsigned mid_tick(int unsigned len);
    return len / 2;
  endfunction

endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [PSC_W-1:0] div,
  output logic             tick,
  output logic             sub_zero
);

  logic [PSC_W-1:0] sub_cnt;

  assign tick     = !hold && (sub_cnt == div);
  assign sub_zero = (sub_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sub_cnt <= '0;
    else if (hold || tick)
      sub_cnt <= '0;
    else
      sub_cnt <= sub_cnt + PSC_W'(1);
  end

  AST_SUB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (sub_cnt <= div)); // R2

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_timer_pkg::*;
#(
  parameter int PSC_W  = 8,
  parameter int TIME_W = 8,
  parameter int OFFSET = 7,
  parameter int CAP    = 2,
  localparam int LEN_W = TIME_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic              stop_req,
  input  logic [PSC_W-1:0]  psc_div,
  input  logic [TIME_W-1:0] low_cnt,
  input  logic [TIME_W-1:0] high_cnt,
  input  logic              tick,
  output phase_e            phase,
  output logic [PSC_W-1:0]  cur_psc,
  output logic [LEN_W-1:0]  cur_len,
  output logic [LEN_W-1:0]  tcnt,
  output logic              phase_end
);

  logic             stop_pend;
  logic             stop_now;
  logic [LEN_W-1:0] len_low_new;
  logic [LEN_W-1:0] len_high_new;

  assign len_low_new  = LEN_W'(phase_ticks(32'(low_cnt), 32'(psc_div),
                                           OFFSET, CAP));
  assign len_high_new = LEN_W'(phase_ticks(32'(high_cnt), 32'(psc_div),
                                           OFFSET, CAP));

  assign phase_end = tick && (tcnt == cur_len - LEN_W'(1));
  assign stop_now  = stop_pend || stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cur_psc   <= '0;
      cur_len   <= '0;
      tcnt      <= '0;
      stop_pend <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          stop_pend <= 1'b0;
          if (run_req) begin
            phase   <= PH_LOW;
            cur_psc <= psc_div;
            cur_len <= len_low_new;
            tcnt    <= '0;
          end
        end
        PH_LOW: begin
          if (stop_req) stop_pend <= 1'b1;
          if (phase_end) begin
            phase   <= PH_HIGH;
            cur_psc <= psc_div;
            cur_len <= len_high_new;
            tcnt    <= '0;
          end else if (tick) begin
            tcnt <= tcnt + LEN_W'(1);
          end
        end
        PH_HIGH: begin
          if (stop_req) stop_pend <= 1'b1;
          if (phase_end) begin
            tcnt <= '0;
            if (stop_now) begin
              phase     <= PH_IDLE;
              stop_pend <= 1'b0;
            end else begin
              phase   <= PH_LOW;
              cur_psc <= psc_div;
              cur_len <= len_low_new;
            end
          end else if (tick) begin
            tcnt <= tcnt + LEN_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !phase_end) |=> ($stable(cur_len) && $stable(cur_psc))); // R8
  AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (cur_len >= LEN_W'(OFFSET - CAP))); // R3
  AST_TCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (tcnt < cur_len)); // R4
  AST_STOP_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && $past(phase) != PH_IDLE) |->
      ($past(phase) == PH_HIGH && $past(stop_now))); // R9

endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
  import scl_timer_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  phase_e           phase,
  input  logic [LEN_W-1:0] tcnt,
  input  logic [LEN_W-1:0] cur_len,
  input  logic             sub_zero,
  output logic             chg_stb,
  output logic             smp_stb
);

  logic [LEN_W-1:0] mid_idx;

  assign mid_idx = LEN_W'(mid_tick(32'(cur_len)));

  always_comb begin
    chg_stb = (phase == PH_LOW)  && (tcnt == '0)     && sub_zero;
    smp_stb = (phase == PH_HIGH) && (tcnt == mid_idx) && sub_zero;
  end

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import scl_timer_pkg::*;
#(
  parameter int PSC_W  = 8,
  parameter int TIME_W = 8,
  parameter int OFFSET = 7,
  parameter int CAP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic              stop_req,
  input  logic [PSC_W-1:0]  psc_div,
  input  logic [TIME_W-1:0] low_cnt,
  input  logic [TIME_W-1:0] high_cnt,
  output logic              scl_pull,
  output logic              chg_stb,
  output logic              smp_stb,
  output logic              active
);

  localparam int LEN_W = TIME_W + 2;

  phase_e           phase;
  logic [PSC_W-1:0] cur_psc;
  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] tcnt;
  logic             phase_end;
  logic             tick;
  logic             sub_zero;
  logic             idle_hold;

  assign idle_hold = (phase == PH_IDLE);
  assign active    = !idle_hold;
  assign scl_pull  = (phase == PH_LOW);

  scl_tick_div #(.PSC_W(PSC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (idle_hold),
    .div      (cur_psc),
    .tick     (tick),
    .sub_zero (sub_zero)
  );

  scl_phase_seq #(
    .PSC_W(PSC_W), .TIME_W(TIME_W), .OFFSET(OFFSET), .CAP(CAP)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_req   (run_req),
    .stop_req  (stop_req),
    .psc_div   (psc_div),
    .low_cnt   (low_cnt),
    .high_cnt  (high_cnt),
    .tick      (tick),
    .phase     (phase),
    .cur_psc   (cur_psc),
    .cur_len   (cur_len),
    .tcnt      (tcnt),
    .phase_end (phase_end)
  );

  scl_strobe_gen #(.LEN_W(LEN_W)) u_stb (
    .phase    (phase),
    .tcnt     (tcnt),
    .cur_len  (cur_len),
    .sub_zero (sub_zero),
    .chg_stb  (chg_stb),
    .smp_stb  (smp_stb)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!scl_pull && !chg_stb && !smp_stb)); // R1
  AST_CHG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> chg_stb); // R7
  AST_SMP_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (active && !scl_pull)); // R7
  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_stb && smp_stb)); // R7

endmodule

// File: tb/i2c_scl_timer_bench.sv
module i2c_scl_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_req = 1'b0;
  logic       stop_req = 1'b0;
  logic [7:0] psc_div = '0;
  logic [7:0] low_cnt = '0;
  logic [7:0] high_cnt = '0;
  logic       scl_pull, chg_stb, smp_stb, active;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    lvl;
    int    cyc;
    int    pos;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  i2c_scl_timer u_i2c_scl_timer (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .stop_req(stop_req),
    .psc_div(psc_div), .low_cnt(low_cnt), .high_cnt(high_cnt),
    .scl_pull(scl_pull), .chg_stb(chg_stb), .smp_stb(smp_stb), .active(active)
  );

  function automatic int plen(int cnt, int p);
    return cnt + 7 - ((p > 2) ? 2 : p);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Scoreboard monitor: measures each phase as a run of scl_pull at one level.
  bit seg_on = 0;
  bit seg_lvl = 0;
  int seg_cnt = 0;
  int stb_pos = 0;
  int stb_n = 0;
  int wrong_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (seg_on && (!active || scl_pull != seg_lvl)) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6", "unexpected phase", seg_cnt, 0);
        end else begin
          exp_t e;
          string ph;
          e  = exp_q.pop_front();
          ph = e.lvl ? "R3 low length" : "R4 high length";
          chk(seg_lvl == e.lvl, e.tag, "phase level", seg_lvl, e.lvl);
          chk(seg_cnt == e.cyc, e.tag, ph, seg_cnt, e.cyc);
          chk(stb_n == 1 && stb_pos == e.pos, e.tag, "R7 strobe position",
              stb_pos, e.pos);
          chk(wrong_n == 0, e.tag, "R7 stray strobe", wrong_n, 0);
        end
        seg_on = 0;
      end
      if (active && !seg_on) begin
        seg_on = 1; seg_lvl = scl_pull; seg_cnt = 0;
        stb_pos = 0; stb_n = 0; wrong_n = 0;
      end
      if (seg_on) begin
        seg_cnt++;
        if (seg_lvl ? chg_stb : smp_stb) begin
          stb_n++;
          stb_pos = seg_cnt;
        end
        if (seg_lvl ? smp_stb : chg_stb) wrong_n++;
      end
    end
  end

  task automatic push_period(int p, int lo, int hi, string tag);
    int ll, lh;
    ll = plen(lo, p);
    lh = plen(hi, p);
    exp_q.push_back('{1'b1, ll * (p + 1), 1, tag});
    exp_q.push_back('{1'b0, lh * (p + 1), (lh / 2) * (p + 1) + 1, tag});
  endtask

  // Ends at the negedge after the run request edge.
  task automatic launch(int p, int lo, int hi, string tag);
    @(negedge clk);
    psc_div = 8'(p); low_cnt = 8'(lo); high_cnt = 8'(hi);
    run_req = 1'b1;
    @(negedge clk);
    run_req = 1'b0;
    chk(active == 1'b1 && scl_pull == 1'b1 && chg_stb == 1'b1, tag,
        "R6 start into low phase", {active, scl_pull, chg_stb}, 3'b111);
  endtask

  task automatic pulse_stop_after(int m);
    repeat (m) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || active) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_m(int p, int lo, int hi, int n, int m, string tag);
    for (int i = 0; i < n; i++) push_period(p, lo, hi, tag);
    launch(p, lo, hi, tag);
    pulse_stop_after(m);
    drain();
  endtask

  function automatic int period(int p, int lo, int hi);
    return (plen(lo, p) + plen(hi, p)) * (p + 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(scl_pull == 0, "R1", "scl released after reset", scl_pull, 0);
    chk(chg_stb == 0 && smp_stb == 0, "R1", "no strobes after reset",
        {chg_stb, smp_stb}, 0);
    chk(active == 0, "R1", "idle after reset", active, 0);

    // R9 stop while idle is ignored
    pulse_stop_after(1);
    repeat (4) @(negedge clk);
    chk(active == 0 && scl_pull == 0, "R9", "stop in idle ignored",
        {active, scl_pull}, 0);

    // R5 standard mode, two periods (R9 stop inside second low phase)
    run_m(0, 53, 53, 2, period(0, 53, 53) + 1, "R5");
    // R5 fast mode, three periods
    run_m(0, 8, 8, 3, 2 * period(0, 8, 8) + 1, "R5");
    // R2 divider 1, uneven counts
    run_m(1, 3, 6, 2, period(1, 3, 6) + 1, "R2");
    // R3 / R4 divider above the cap, minimum counts
    run_m(4, 0, 1, 2, period(4, 0, 1) + 1, "R4");
    // R9 stop on the last cycle of the first high phase: one period
    run_m(0, 2, 3, 1, period(0, 2, 3) - 1, "R9");
    // R9 stop one cycle later: two periods
    run_m(0, 2, 3, 2, period(0, 2, 3), "R9");

    // R8 mid-phase register changes, R6 run while active ignored
    exp_q.push_back('{1'b1, 17, 1, "R8"});
    exp_q.push_back('{1'b0, 36, 17, "R8"});
    exp_q.push_back('{1'b1, 100, 1, "R8"});
    exp_q.push_back('{1'b0, 36, 17, "R8"});
    launch(0, 10, 12, "R8");
    repeat (2) @(negedge clk);
    psc_div = 8'd3; low_cnt = 8'd20; high_cnt = 8'd4;
    repeat (27) @(negedge clk);
    run_req = 1'b1;
    @(negedge clk);
    run_req = 1'b0;
    pulse_stop_after(29);
    drain();

    // R1 idle after all runs
    chk(active == 0 && scl_pull == 0 && !chg_stb && !smp_stb, "R1",
        "idle at end", {active, scl_pull, chg_stb, smp_stb}, 0);
    chk(exp_q.size() == 0, "R6", "all expected phases seen", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule